// File: doc/BRIEF.md
# Prefixed Rotate, Shift and Bit Execution Unit

This block executes the second-byte opcode group of an 8-bit processor that covers rotates, shifts and single-bit test, clear and set. Each issue carries the opcode byte, the operand that the surrounding pipeline has already fetched (from a register or from the byte addressed by HL), and the current flag byte. One clock later the unit presents the result byte, whether that byte must be written back, where it goes (register index, or a memory marker for the HL operand), and the new flag byte.

The opcode is split into a two-bit group field (bits 7:6), a three-bit selector (bits 5:3) and a three-bit operand field (bits 2:0). Group 0 picks one of eight rotate or shift kinds by the selector; groups 1, 2 and 3 are bit test, bit clear and bit set, with the selector naming the bit. Register fetch and the write-back itself belong to the surrounding pipeline.

Top module: `rsb_unit`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls with no issue, `done`, `wb_en`, `dst_mem` are low and `result`, `dst_idx`, `flags_out` are zero.
- R2: The outputs for an issue appear on the clock edge after `issue` is sampled high; `dst_idx` equals opcode bits 2:0 and `dst_mem` is high exactly when those bits are 6.
- R3: Group 0, selector 0 (rotate left circular): bit 7 of the operand goes to result bit 0 and to carry.
- R4: Group 0, selector 1 (rotate right circular): bit 0 of the operand goes to result bit 7 and to carry.
- R5: Group 0, selectors 2 and 3 (rotate left / right through carry): the incoming carry (`flags_in` bit 0) enters at bit 0 (left) or bit 7 (right); the bit leaving becomes the new carry.
- R6: Group 0, selectors 4, 5 and 7: left shift fills bit 0 with 0; arithmetic right shift keeps bit 7; logical right shift fills bit 7 with 0; the bit shifted out becomes carry.
- R7: Group 0, selector 6: left shift that forces bit 0 to 1, with bit 7 of the operand going to carry.
- R8: For group 0 the flag byte is rebuilt with sign at bit 7 = result bit 7, zero at bit 6 = result is zero, parity at bit 2 = result has even parity, carry at bit 0; bits 5, 4, 3 and 1 (half-carry at 4, subtract at 1) are 0. `wb_en` is high.
- R9: Group 1 (bit test): `wb_en` is low, `result` equals the operand, flag bit 6 is set when the selected bit is 0, bit 4 is set, bit 1 is cleared, every other flag bit is taken from `flags_in`.
- R10: Groups 2 and 3: the result is the operand with the selected bit cleared (group 2) or set (group 3), `wb_en` is high and `flags_out` equals `flags_in`.
- R11: A cycle with `issue` low leaves `done` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Opcode, operand and flags are valid this cycle |
| opcode | input | 8 | Second opcode byte |
| operand | input | 8 | Fetched operand value |
| flags_in | input | 8 | Current flag byte |
| done | output | 1 | Outputs below belong to the previous issue |
| result | output | 8 | Result byte |
| wb_en | output | 1 | Result must be written back |
| dst_idx | output | 3 | Destination register index (operand field) |
| dst_mem | output | 1 | Destination is the byte addressed by HL |
| flags_out | output | 8 | New flag byte |

## Verification
The unit holds state only in its output register, so a wrong internal value shows up on the very next cycle as a wrong result, flag, destination or a stray `done`, and never lingers beyond the following issue. Every one of the 256 opcodes is driven against operands that exercise all-zero, all-one, single high and low bits and alternating patterns, with the incoming carry both set and clear, so a wrong fill bit, swapped carry source or misplaced flag is caught on the issue that exposes it.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;
    localparam int MSB    = DATA_W - 1;

    // flag byte positions
    localparam int FL_S = 7;
    localparam int FL_Z = 6;
    localparam int FL_H = 4;
    localparam int FL_P = 2;
    localparam int FL_N = 1;
    localparam int FL_C = 0;

    localparam logic [SEL_W-1:0] MEM_OPERAND = 3'd6;

    typedef enum logic [3:0] {
        K_RLC = 4'd0,
        K_RRC = 4'd1,
        K_RL  = 4'd2,
        K_RR  = 4'd3,
        K_SLA = 4'd4,
        K_SRA = 4'd5,
        K_SLL = 4'd6,
        K_SRL = 4'd7,
        K_BIT = 4'd8,
        K_RES = 4'd9,
        K_SET = 4'd10
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic [SEL_W-1:0]  bit_sel;
        logic [SEL_W-1:0]  reg_sel;
        logic              is_mem;
    } dec_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
    } shift_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wb_en;
        logic [SEL_W-1:0]  dst_idx;
        logic              dst_mem;
        logic [DATA_W-1:0] flags;
    } out_t;

    function automatic logic even_parity(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic is_shift_kind(input op_kind_e k);
        return k <= K_SRL;
    endfunction

endpackage

// File: rtl/rsb_decode.sv
module rsb_decode
    import rsb_pkg::*;
(
    input  logic [DATA_W-1:0] opcode,
    output dec_t              dec
);
    logic [1:0]       grp;
    logic [SEL_W-1:0] sel;

    assign grp = opcode[7:6];
    assign sel = opcode[5:3];

    always_comb begin
        dec.bit_sel = sel;
        dec.reg_sel = opcode[2:0];
        dec.is_mem  = (opcode[2:0] == MEM_OPERAND);
        unique case (grp)
            2'd0:    dec.kind = op_kind_e'({1'b0, sel});
            2'd1:    dec.kind = K_BIT;
            2'd2:    dec.kind = K_RES;
            default: dec.kind = K_SET;
        endcase
    end
endmodule

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
(
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] value,
    input  logic              carry_in,
    output shift_t            out
);
    always_comb begin
        out = '{value: value, carry: carry_in};
        case (kind)
            K_RLC: out = '{value: {value[MSB-1:0], value[MSB]}, carry: value[MSB]};
            K_RRC: out = '{value: {value[0], value[MSB:1]},     carry: value[0]};
            K_RL:  out = '{value: {value[MSB-1:0], carry_in},   carry: value[MSB]};
            K_RR:  out = '{value: {carry_in, value[MSB:1]},     carry: value[0]};
            K_SLA: out = '{value: {value[MSB-1:0], 1'b0},       carry: value[MSB]};
            K_SRA: out = '{value: {value[MSB], value[MSB:1]},   carry: value[0]};
            K_SLL: out = '{value: {value[MSB-1:0], 1'b1},       carry: value[MSB]};
            K_SRL: out = '{value: {1'b0, value[MSB:1]},         carry: value[0]};
            default: ;
        endcase
    end
endmodule

// File: rtl/rsb_bitops.sv
module rsb_bitops
    import rsb_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic              bit_zero,
    output logic [DATA_W-1:0] cleared,
    output logic [DATA_W-1:0] set_val
);
    logic [DATA_W-1:0] mask;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (bit_sel == SEL_W'(i));
    end

    assign bit_zero = ~|(value & mask);
    assign cleared  = value & ~mask;
    assign set_val  = value | mask;
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [7:0]        opcode,
    input  logic [7:0]        operand,
    input  logic [7:0]        flags_in,
    output logic              done,
    output logic [7:0]        result,
    output logic              wb_en,
    output logic [2:0]        dst_idx,
    output logic              dst_mem,
    output logic [7:0]        flags_out
);
    dec_t              dec;
    shift_t            sh;
    logic              bit_zero;
    logic [DATA_W-1:0] cleared, set_val;
    out_t              nxt, cur;
    logic              done_q;

    rsb_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    rsb_shifter u_sh (
        .kind     (dec.kind),
        .value    (operand),
        .carry_in (flags_in[FL_C]),
        .out      (sh)
    );

    rsb_bitops u_bit (
        .value    (operand),
        .bit_sel  (dec.bit_sel),
        .bit_zero (bit_zero),
        .cleared  (cleared),
        .set_val  (set_val)
    );

    always_comb begin
        nxt.dst_idx = dec.reg_sel;
        nxt.dst_mem = dec.is_mem;
        nxt.wb_en   = 1'b1;
        nxt.result  = operand;
        nxt.flags   = flags_in;
        if (is_shift_kind(dec.kind)) begin
            nxt.result       = sh.value;
            nxt.flags        = '0;
            nxt.flags[FL_S]  = sh.value[MSB];
            nxt.flags[FL_Z]  = (sh.value == '0);
            nxt.flags[FL_P]  = even_parity(sh.value);
            nxt.flags[FL_C]  = sh.carry;
        end else begin
            case (dec.kind)
                K_BIT: begin
                    nxt.wb_en       = 1'b0;
                    nxt.flags[FL_Z] = bit_zero;
                    nxt.flags[FL_H] = 1'b1;
                    nxt.flags[FL_N] = 1'b0;
                end
                K_RES:   nxt.result = cleared;
                K_SET:   nxt.result = set_val;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= issue;
            if (issue) cur <= nxt;
            else       cur <= '0;
        end
    end

    assign done      = done_q;
    assign result    = cur.result;
    assign wb_en     = cur.wb_en;
    assign dst_idx   = cur.dst_idx;
    assign dst_mem   = cur.dst_mem;
    assign flags_out = cur.flags;

    // R9: no write-back only for bit test, which always reports H=1, N=0
    a_r9_test_flags: assert property (@(posedge clk) disable iff (rst)
        done && !wb_en |-> flags_out[FL_H] && !flags_out[FL_N]);

    // R2: memory marker only for operand field 6
    a_r2_mem_index: assert property (@(posedge clk) disable iff (rst)
        done && dst_mem |-> dst_idx == MEM_OPERAND);

    // R10: clear/set leave flags untouched and write back
    a_r10_flags_kept: assert property (@(posedge clk) disable iff (rst)
        issue && opcode[7] |=> done && wb_en && flags_out == $past(flags_in));

    // R8: zero and parity flags track the produced result
    a_r8_zero_parity: assert property (@(posedge clk) disable iff (rst)
        issue && opcode[7:6] == 2'd0 |=> wb_en && flags_out[FL_Z] == (result == '0)
                                         && flags_out[FL_P] == ~(^result)
                                         && flags_out[FL_S] == result[MSB]);

    // R11: idle cycle yields no completion
    a_r11_idle: assert property (@(posedge clk) disable iff (rst)
        !issue |=> !done);
endmodule

// File: tb/rsb_unit_tb_top.sv
module rsb_unit_tb_top;

    typedef struct {
        logic [7:0] result;
        logic       wb_en;
        logic [2:0] idx;
        logic       mem;
        logic [7:0] flags;
        logic [7:0] op;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       issue = 1'b0;
    logic [7:0] opcode = '0, operand = '0, flags_in = '0;
    logic       done, wb_en, dst_mem;
    logic [7:0] result, flags_out;
    logic [2:0] dst_idx;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    rsb_unit dut_i (
        .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
        .operand(operand), .flags_in(flags_in), .done(done),
        .result(result), .wb_en(wb_en), .dst_idx(dst_idx),
        .dst_mem(dst_mem), .flags_out(flags_out)
    );

    function automatic string tag_of(logic [7:0] op);
        if (op[7:6] == 2'd1) return "R9";
        if (op[7]) return "R10";
        case (op[5:3])
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd6: return "R7";
            default: return "R6";
        endcase
    endfunction

    function automatic exp_t model(logic [7:0] op, logic [7:0] v, logic [7:0] f);
        exp_t e;
        logic [2:0] y;
        logic       c;
        logic       co;
        logic [7:0] r;
        y = op[5:3];
        c = f[0];
        co = 1'b0;
        r = v;
        e.op = op;
        e.idx = op[2:0];
        e.mem = (op[2:0] == 3'd6);
        e.wb_en = 1'b1;
        e.flags = f;
        case (op[7:6])
            2'd0: begin
                case (y)
                    3'd0: begin r = {v[6:0], v[7]}; co = v[7]; end
                    3'd1: begin r = {v[0], v[7:1]}; co = v[0]; end
                    3'd2: begin r = {v[6:0], c};    co = v[7]; end
                    3'd3: begin r = {c, v[7:1]};    co = v[0]; end
                    3'd4: begin r = v << 1;         co = v[7]; end
                    3'd5: begin r = {v[7], v[7:1]}; co = v[0]; end
                    3'd6: begin r = (v << 1) | 8'h01; co = v[7]; end
                    default: begin r = v >> 1;      co = v[0]; end
                endcase
                e.flags = {r[7], (r == 8'h00), 3'b000, ~(^r), 1'b0, co};
            end
            2'd1: begin
                e.wb_en = 1'b0;
                e.flags[6] = ~v[y];
                e.flags[4] = 1'b1;
                e.flags[1] = 1'b0;
            end
            2'd2: r[y] = 1'b0;
            default: r[y] = 1'b1;
        endcase
        e.result = r;
        return e;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(logic [7:0] op, logic [7:0] v, logic [7:0] f);
        @(negedge clk);
        issue = 1'b1;
        opcode = op;
        operand = v;
        flags_in = f;
        q.push_back(model(op, v, f));
    endtask

    task automatic idle();
        @(negedge clk);
        issue = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                check("R11", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                string t;
                e = q.pop_front();
                t = tag_of(e.op);
                check(t, $sformatf("result op=%h", e.op), result, e.result);
                check(t, $sformatf("wb_en op=%h", e.op), wb_en, e.wb_en);
                check(e.op[7:6] == 2'd0 ? "R8" : t,
                      $sformatf("flags op=%h", e.op), flags_out, e.flags);
                check("R2", $sformatf("dst_idx op=%h", e.op), dst_idx, e.idx);
                check("R2", $sformatf("dst_mem op=%h", e.op), dst_mem, e.mem);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] pats[6];
        logic [7:0] flg[3];
        pats = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A};
        flg  = '{8'h00, 8'hFF, 8'h29};

        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1", "done in reset", done, 0);
        check("R1", "result in reset", result, 0);
        check("R1", "flags in reset", flags_out, 0);
        check("R1", "wb_en in reset", wb_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", done, 0);
        check("R1", "dst_mem after reset", dst_mem, 0);

        // directed corners
        send(8'h00, 8'h85, 8'h00);   // R3: 85 -> 0B, carry 1
        send(8'h0E, 8'h01, 8'h00);   // R4: memory operand, 01 -> 80
        send(8'h10, 8'h80, 8'h00);   // R5: RL, carry 0 in, result 00, Z set
        send(8'h18, 8'h00, 8'h01);   // R5: RR, carry 1 enters bit 7
        send(8'h30, 8'h80, 8'h00);   // R7: 80 -> 01 with carry
        send(8'h2F, 8'h81, 8'h00);   // R6: SRA keeps bit 7
        send(8'h7E, 8'h7F, 8'hC5);   // R9: test bit 7 (zero)
        send(8'hBE, 8'hFF, 8'h12);   // R10: clear bit 7
        send(8'hC0, 8'h00, 8'h34);   // R10: set bit 0
        idle();
        // R11: idle cycle produces no completion
        @(negedge clk);
        check("R11", "done after idle", done, 0);

        for (int op = 0; op < 256; op++) begin
            for (int p = 0; p < 6; p++) begin
                send(8'(op), pats[p], flg[(op + p) % 3]);
            end
        end
        idle();
        repeat (3) @(negedge clk);
        check("R11", "queue drained", q.size(), 0);
        check("R11", "done idle at end", done, 0);
        finish_run();
    end
endmodule